// File: doc/BRIEF.md
# Multi-Stream Sequential Prefetch Buffer

This block sits next to a cache and keeps several independent streams of lines fetched ahead of demand. Each stream is a short ring of line slots, each slot holding a line address, its data and a fill state. When the cache misses, it presents the missing line number on the lookup port. The block compares that line against every slot of every stream. If the line is found, the block hands its data back to the cache. It then discards that slot and every slot ahead of it, and reuses the freed slots for the lines that follow the stream's current last line.

If no stream holds the line, the block flushes the stream used least recently and restarts it at the line after the missing one. It reports a miss, and the cache fetches the line itself. Prefetched data never enters the cache unless a lookup asks for it.

A single memory request port serves all streams. It issues at most one request per cycle, and the streams take turns in round-robin order. Each request carries a tag naming the stream and the slot. A response updates its slot only when the slot still waits for that data. A response that belongs to a flushed slot is dropped.

Top module: `spf_prefetcher`

## Requirements
- R1: After reset, miss_ready is 1, res_valid is 0 and mreq_valid is 0, and mreq_valid stays 0 until the first lookup.
- R2: A lookup on line X that no stream holds produces a result with res_hit=0. It restarts the least recently used stream (after reset the order is stream 0, 1, 2, 3), and that stream requests exactly lines X+1 to X+DEPTH, in ascending order.
- R3: Separate streams track interleaved sequences independently: a lookup that hits one stream leaves the lines held by the other streams intact.
- R4: A lookup that hits returns one res_valid pulse with res_hit=1, res_line equal to the looked-up line and res_data equal to the response data delivered for that line. miss_ready is high again in the same cycle as the pulse.
- R5: A lookup is compared against every slot of a stream, not only the oldest one. A hit on a later slot discards all older slots of that stream, so a later lookup of a discarded line misses.
- R6: The slots freed by a hit are refilled with the lines following the stream's last line, and a later lookup of such a refilled line hits.
- R7: A hit on a slot whose data has not yet arrived keeps miss_ready low until the data is back, and then delivers it.
- R8: At most one request is issued per cycle. Streams with pending work are served round-robin, starting at stream 0 after reset.
- R9: A response for a slot flushed while its request was outstanding is discarded. The slot is not requested again until that response has come back, so the data delivered for the new line is the new line's data.
- R10: mreq_id carries the stream index in its upper bits and the slot index in its low $clog2(DEPTH) bits. A response names its slot by echoing that value on mrsp_id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Cache presents a missing line |
| miss_line | input | ADDR_W | Missing line number |
| miss_ready | output | 1 | Block can accept a lookup |
| res_valid | output | 1 | One-cycle lookup result pulse |
| res_hit | output | 1 | 1 when the line came from a stream |
| res_line | output | ADDR_W | Line the result belongs to |
| res_data | output | DATA_W | Line data on a hit, zero on a miss |
| mreq_valid | output | 1 | Memory request present |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_line | output | ADDR_W | Line to fetch |
| mreq_id | output | SID_W+SLOT_W | Stream and slot tag of the request |
| mrsp_valid | input | 1 | Memory response present |
| mrsp_id | input | SID_W+SLOT_W | Tag echoed from the request |
| mrsp_data | input | DATA_W | Returned line data |

## Verification
A wrong ring head or refill line shows up on the memory port within a few cycles, as a request for the wrong line or in the wrong order. It also shows up on the next lookup of that stream, as a hit where a miss was due or the reverse. A bad recency order only surfaces when the next allocation picks the wrong stream, which can take several lookups to show. For that reason the lookup sequence is laid out so that every allocation's victim decides a later hit or miss. A stale response written into a reused slot shows as wrong res_data one memory latency later. The bench stretches that latency so the flushed requests are still in flight when their slots are reused.

// File: rtl/spf_pkg.sv
package spf_pkg;

   // fill state of one stream slot
   typedef enum logic [1:0] {
      SLOT_ISSUE = 2'd0,   // line assigned, request not yet sent
      SLOT_PEND  = 2'd1,   // request sent, data outstanding
      SLOT_FULL  = 2'd2    // data present
   } slot_state_e;

   // lookup sequencer
   typedef enum logic {
      LK_IDLE   = 1'b0,
      LK_SEARCH = 1'b1
   } lk_state_e;

endpackage

// File: rtl/spf_stream.sv
module spf_stream #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4,
   localparam int SLOT_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_line_i,
   input  logic              alloc_i,
   input  logic              adv_i,
   output logic              match_o,
   output logic              match_full_o,
   output logic [DATA_W-1:0] match_data_o,
   output logic              issue_want_o,
   output logic [SLOT_W-1:0] issue_slot_o,
   output logic [ADDR_W-1:0] issue_line_o,
   input  logic              issue_grant_i,
   input  logic              rsp_valid_i,
   input  logic [SLOT_W-1:0] rsp_slot_i,
   input  logic [DATA_W-1:0] rsp_data_i
);
   import spf_pkg::*;

   logic              valid_q;
   logic [SLOT_W-1:0] head_q;
   logic [ADDR_W-1:0] next_q;
   logic [ADDR_W-1:0] line_q [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];
   slot_state_e       st_q   [DEPTH];
   logic [DEPTH-1:0]  stale_q;

   logic [SLOT_W-1:0] phys     [DEPTH];  // physical slot of logical position
   logic [SLOT_W-1:0] logi     [DEPTH];  // logical position of physical slot
   logic [ADDR_W-1:0] new_line [DEPTH];
   logic [DEPTH-1:0]  recycle;
   logic [DEPTH-1:0]  rsp_here;
   logic [SLOT_W-1:0] match_pos;

   always_comb begin
      for (int j = 0; j < DEPTH; j++) begin
         phys[j] = head_q + SLOT_W'(j);
         logi[j] = SLOT_W'(j) - head_q;
      end
   end

   // compare against every slot, oldest match wins
   always_comb begin
      match_o      = 1'b0;
      match_full_o = 1'b0;
      match_data_o = '0;
      match_pos    = '0;
      for (int j = DEPTH - 1; j >= 0; j--) begin
         if (valid_q && line_q[phys[j]] == lk_line_i) begin
            match_o      = 1'b1;
            match_pos    = SLOT_W'(j);
            match_full_o = (st_q[phys[j]] == SLOT_FULL);
            match_data_o = data_q[phys[j]];
         end
      end
   end

   // oldest slot still needing a request, blocked while a stale reply is due
   always_comb begin
      issue_want_o = 1'b0;
      issue_slot_o = '0;
      for (int j = DEPTH - 1; j >= 0; j--) begin
         if (valid_q && st_q[phys[j]] == SLOT_ISSUE && !stale_q[phys[j]]) begin
            issue_want_o = 1'b1;
            issue_slot_o = phys[j];
         end
      end
      issue_line_o = line_q[issue_slot_o];
   end

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         rsp_here[i] = rsp_valid_i && (rsp_slot_i == SLOT_W'(i));
         recycle[i]  = alloc_i || (adv_i && (logi[i] <= match_pos));
         new_line[i] = alloc_i ? lk_line_i + ADDR_W'(i + 1)
                               : next_q + ADDR_W'(logi[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         head_q  <= '0;
         next_q  <= '0;
         stale_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            line_q[i] <= '0;
            data_q[i] <= '0;
            st_q[i]   <= SLOT_ISSUE;
         end
      end else begin
         if (alloc_i) begin
            valid_q <= 1'b1;
            head_q  <= '0;
            next_q  <= lk_line_i + ADDR_W'(DEPTH + 1);
         end else if (adv_i) begin
            head_q  <= head_q + match_pos + 1'b1;
            next_q  <= next_q + ADDR_W'(match_pos) + 1'b1;
         end
         for (int i = 0; i < DEPTH; i++) begin
            if (recycle[i]) begin
               line_q[i]  <= new_line[i];
               st_q[i]    <= SLOT_ISSUE;
               stale_q[i] <= !rsp_here[i] && (stale_q[i] || st_q[i] == SLOT_PEND);
            end else begin
               if (issue_grant_i && issue_slot_o == SLOT_W'(i)) begin
                  st_q[i] <= SLOT_PEND;
               end
               if (rsp_here[i]) begin
                  if (stale_q[i]) begin
                     stale_q[i] <= 1'b0;
                  end else if (st_q[i] == SLOT_PEND) begin
                     st_q[i]   <= SLOT_FULL;
                     data_q[i] <= rsp_data_i;
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/spf_rr_arb.sv
module spf_rr_arb #(
   parameter int N = 4,
   localparam int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     want_i,
   input  logic             fire_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   logic [IDX_W-1:0] ptr_q;
   int cand [N];

   always_comb begin
      for (int k = 0; k < N; k++) begin
         cand[k] = int'(ptr_q) + k;
         if (cand[k] >= N) cand[k] = cand[k] - N;
      end
   end

   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (want_i[cand[k]]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(cand[k]);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (fire_i) begin
         ptr_q <= (idx_o == IDX_W'(N - 1)) ? '0 : idx_o + 1'b1;
      end
   end

endmodule

// File: rtl/spf_lru.sv
module spf_lru #(
   parameter int N = 4,
   localparam int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_i,
   input  logic [IDX_W-1:0] touch_idx_i,
   output logic [IDX_W-1:0] lru_o
);
   // rank 0 = most recent, N-1 = least recent
   logic [IDX_W-1:0] rank_q [N];
   logic [IDX_W-1:0] touched_rank;

   assign touched_rank = rank_q[touch_idx_i];

   always_comb begin
      lru_o = '0;
      for (int i = 0; i < N; i++) begin
         if (rank_q[i] == IDX_W'(N - 1)) lru_o = IDX_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) rank_q[i] <= IDX_W'(N - 1 - i);
      end else if (touch_i) begin
         for (int i = 0; i < N; i++) begin
            if (touch_idx_i == IDX_W'(i)) begin
               rank_q[i] <= '0;
            end else if (rank_q[i] < touched_rank) begin
               rank_q[i] <= rank_q[i] + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/spf_prefetcher.sv
module spf_prefetcher #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 32,
   parameter int NUM_STREAMS = 4,
   parameter int DEPTH       = 4,
   localparam int SID_W  = $clog2(NUM_STREAMS),
   localparam int SLOT_W = $clog2(DEPTH),
   localparam int ID_W   = SID_W + SLOT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [ADDR_W-1:0] miss_line,
   output logic              miss_ready,
   output logic              res_valid,
   output logic              res_hit,
   output logic [ADDR_W-1:0] res_line,
   output logic [DATA_W-1:0] res_data,
   output logic              mreq_valid,
   input  logic              mreq_ready,
   output logic [ADDR_W-1:0] mreq_line,
   output logic [ID_W-1:0]   mreq_id,
   input  logic              mrsp_valid,
   input  logic [ID_W-1:0]   mrsp_id,
   input  logic [DATA_W-1:0] mrsp_data
);
   import spf_pkg::*;

   // elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (NUM_STREAMS < 2 || (NUM_STREAMS & (NUM_STREAMS - 1)) != 0) begin : g_bad_streams
      $error("NUM_STREAMS must be a power of two, at least 2");
   end
   if (ADDR_W < SLOT_W + 2) begin : g_bad_addr
      $error("ADDR_W too narrow for DEPTH");
   end

   lk_state_e         lk_q;
   logic [ADDR_W-1:0] lk_line_q;

   logic [NUM_STREAMS-1:0] s_match, s_full, s_want, s_alloc, s_adv, s_grant, s_rsp;
   logic [DATA_W-1:0]      s_data [NUM_STREAMS];
   logic [SLOT_W-1:0]      s_slot [NUM_STREAMS];
   logic [ADDR_W-1:0]      s_line [NUM_STREAMS];

   logic             any_hit, sel_full, do_adv, do_alloc, mreq_fire, arb_any;
   logic [SID_W-1:0] sel, lru_idx, gidx;
   logic [DATA_W-1:0] sel_data;

   assign miss_ready = (lk_q == LK_IDLE);

   for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
      assign s_alloc[s] = do_alloc && (lru_idx == SID_W'(s));
      assign s_adv[s]   = do_adv && (sel == SID_W'(s));
      assign s_grant[s] = mreq_fire && (gidx == SID_W'(s));
      assign s_rsp[s]   = mrsp_valid && (mrsp_id[ID_W-1:SLOT_W] == SID_W'(s));

      spf_stream #(
         .ADDR_W (ADDR_W),
         .DATA_W (DATA_W),
         .DEPTH  (DEPTH)
      ) u_stream (
         .clk           (clk),
         .rst_n         (rst_n),
         .lk_line_i     (lk_line_q),
         .alloc_i       (s_alloc[s]),
         .adv_i         (s_adv[s]),
         .match_o       (s_match[s]),
         .match_full_o  (s_full[s]),
         .match_data_o  (s_data[s]),
         .issue_want_o  (s_want[s]),
         .issue_slot_o  (s_slot[s]),
         .issue_line_o  (s_line[s]),
         .issue_grant_i (s_grant[s]),
         .rsp_valid_i   (s_rsp[s]),
         .rsp_slot_i    (mrsp_id[SLOT_W-1:0]),
         .rsp_data_i    (mrsp_data)
      );
   end

   // lowest-numbered matching stream is taken
   always_comb begin
      any_hit = 1'b0;
      sel     = '0;
      for (int s = NUM_STREAMS - 1; s >= 0; s--) begin
         if (s_match[s]) begin
            any_hit = 1'b1;
            sel     = SID_W'(s);
         end
      end
   end

   assign sel_full = s_full[sel];
   assign sel_data = s_data[sel];
   assign do_adv   = (lk_q == LK_SEARCH) && any_hit && sel_full;
   assign do_alloc = (lk_q == LK_SEARCH) && !any_hit;

   // a stream being rewritten this cycle does not issue
   spf_rr_arb #(.N(NUM_STREAMS)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .want_i (s_want & ~(s_alloc | s_adv)),
      .fire_i (mreq_fire),
      .any_o  (arb_any),
      .idx_o  (gidx)
   );

   assign mreq_valid = arb_any;
   assign mreq_fire  = mreq_valid && mreq_ready;
   assign mreq_line  = s_line[gidx];
   assign mreq_id    = {gidx, s_slot[gidx]};

   spf_lru #(.N(NUM_STREAMS)) u_lru (
      .clk         (clk),
      .rst_n       (rst_n),
      .touch_i     (do_adv || do_alloc),
      .touch_idx_i (do_adv ? sel : lru_idx),
      .lru_o       (lru_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_q      <= LK_IDLE;
         lk_line_q <= '0;
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_line  <= '0;
         res_data  <= '0;
      end else begin
         res_valid <= do_adv || do_alloc;
         if (do_adv || do_alloc) begin
            res_hit  <= do_adv;
            res_line <= lk_line_q;
            res_data <= do_adv ? sel_data : '0;
         end
         case (lk_q)
            LK_IDLE: begin
               if (miss_valid) begin
                  lk_q      <= LK_SEARCH;
                  lk_line_q <= miss_line;
               end
            end
            LK_SEARCH: begin
               if (do_adv || do_alloc) lk_q <= LK_IDLE;
            end
            default: lk_q <= LK_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
   parameter int ADDR_W      = 16,
   parameter int NUM_STREAMS = 4,
   parameter int DEPTH       = 4,
   localparam int ID_W = $clog2(NUM_STREAMS) + $clog2(DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              miss_valid,
   input logic              miss_ready,
   input logic [ADDR_W-1:0] miss_line,
   input logic              res_valid,
   input logic [ADDR_W-1:0] res_line,
   input logic              mreq_valid,
   input logic              mreq_ready,
   input logic [ID_W-1:0]   mreq_id,
   input logic              mrsp_valid,
   input logic [ID_W-1:0]   mrsp_id
);
   logic [(1 << ID_W)-1:0] outst_q;
   logic [ADDR_W-1:0]      acc_line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outst_q    <= '0;
         acc_line_q <= '0;
      end else begin
         if (mrsp_valid) outst_q[mrsp_id] <= 1'b0;
         if (mreq_valid && mreq_ready) outst_q[mreq_id] <= 1'b1;
         if (miss_valid && miss_ready) acc_line_q <= miss_line;
      end
   end

   // R9: a tag is never reused while its earlier response is outstanding
   assert_no_reissue_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq_valid && mreq_ready) |-> !outst_q[mreq_id])
      else $error("tag reissued while outstanding");

   // R7: an accepted lookup holds the port busy for at least one cycle
   assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && miss_ready) |=> !miss_ready)
      else $error("lookup port not busy after accept");

   // R2: a result only follows a search cycle
   assert_result_after_search_R2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(!miss_ready))
      else $error("result without search");

   // R4: result names the accepted line, single-cycle pulse
   assert_result_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_line == acc_line_q))
      else $error("result line mismatch");

   assert_result_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid)
      else $error("result longer than one cycle");

endmodule

bind spf_prefetcher spf_checker #(
   .ADDR_W      (ADDR_W),
   .NUM_STREAMS (NUM_STREAMS),
   .DEPTH       (DEPTH)
) u_chk (.*);

// File: tb/tb_spf_prefetcher.sv
module tb_spf_prefetcher;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int NS = 4;
   localparam int D  = 4;
   localparam int IW = 4;
   localparam int NV = 14;

   // {expected hit, line}
   localparam logic [AW:0] VEC [NV] = '{
      17'h00100, 17'h10101, 17'h00200, 17'h10102, 17'h10202, 17'h00201, 17'h10106,
      17'h00300, 17'h00400, 17'h10203, 17'h00500, 17'h00107, 17'h10108, 17'h10402
   };

   function automatic string vtag(input int i);
      case (i)
         1:          return "R4";
         2, 3, 12:   return "R3";
         4, 5, 9, 13: return "R5";
         6:          return "R6";
         default:    return "R2";
      endcase
   endfunction

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic miss_valid = 1'b0;
   logic [AW-1:0] miss_line = '0;
   logic miss_ready, res_valid, res_hit, mreq_valid;
   logic [AW-1:0] res_line, mreq_line;
   logic [DW-1:0] res_data;
   logic mreq_ready = 1'b1;
   logic [IW-1:0] mreq_id;
   logic mrsp_valid = 1'b0;
   logic [IW-1:0] mrsp_id = '0;
   logic [DW-1:0] mrsp_data = '0;

   always #4 clk = ~clk;

   spf_prefetcher #(.ADDR_W(AW), .DATA_W(DW), .NUM_STREAMS(NS), .DEPTH(D)) dut (.*);

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int lat = 6;

   logic [AW-1:0] q_line [64];
   logic [IW-1:0] q_id   [64];
   int            q_due  [64];
   int q_hd = 0, q_tl = 0, q_cnt = 0;

   bit rec_en = 0;
   int rec_n = 0;
   logic [AW-1:0] rec_line [16];
   logic [IW-1:0] rec_id   [16];

   function automatic logic [DW-1:0] fdata(input logic [AW-1:0] l);
      return {~l, l};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // memory model: fixed latency, in-order replies
   initial begin
      forever begin
         @(negedge clk);
         #1;
         cyc++;
         mrsp_valid = 1'b0;
         if (rst_n && q_cnt > 0 && q_due[q_hd] <= cyc) begin
            mrsp_valid = 1'b1;
            mrsp_id    = q_id[q_hd];
            mrsp_data  = fdata(q_line[q_hd]);
            q_hd  = (q_hd + 1) % 64;
            q_cnt--;
         end
         if (rst_n && mreq_valid && mreq_ready) begin
            q_line[q_tl] = mreq_line;
            q_id[q_tl]   = mreq_id;
            q_due[q_tl]  = cyc + lat;
            q_tl  = (q_tl + 1) % 64;
            q_cnt++;
            if (rec_en) begin
               if (rec_n < 16) begin
                  rec_line[rec_n] = mreq_line;
                  rec_id[rec_n]   = mreq_id;
               end
               rec_n++;
            end
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      miss_valid = 1'b0;
      mreq_ready = 1'b1;
      q_hd = 0; q_tl = 0; q_cnt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic do_lookup(input logic [AW-1:0] ln, output logic hit,
                            output logic [DW-1:0] dat, output logic [AW-1:0] rl,
                            output int waited);
      int n;
      @(negedge clk);
      miss_valid = 1'b1;
      miss_line  = ln;
      @(negedge clk);
      miss_valid = 1'b0;
      n = 0;
      while (!res_valid && n < 2000) begin
         @(negedge clk);
         n++;
      end
      hit = res_hit; dat = res_data; rl = res_line; waited = n;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic hit;
      logic [DW-1:0] dat;
      logic [AW-1:0] rl;
      int w;

      // reset state (R1)
      do_reset();
      @(negedge clk);
      chk(miss_ready == 1'b1, "R1", "miss_ready", 64'(miss_ready), 64'd1);
      chk(res_valid == 1'b0, "R1", "res_valid", 64'(res_valid), 64'd0);
      chk(mreq_valid == 1'b0, "R1", "mreq_valid", 64'(mreq_valid), 64'd0);
      repeat (5) @(negedge clk);
      chk(mreq_valid == 1'b0, "R1", "mreq_valid idle", 64'(mreq_valid), 64'd0);

      // request order, round-robin and tag layout (R2, R8, R10)
      do_reset();
      mreq_ready = 1'b0;
      do_lookup(16'h0700, hit, dat, rl, w);
      chk(hit == 1'b0, "R2", "res_hit 0700", 64'(hit), 64'd0);
      do_lookup(16'h0800, hit, dat, rl, w);
      chk(hit == 1'b0, "R2", "res_hit 0800", 64'(hit), 64'd0);
      rec_n = 0;
      rec_en = 1;
      @(negedge clk);
      mreq_ready = 1'b1;
      repeat (20) @(negedge clk);
      rec_en = 0;
      chk(rec_n == 2 * D, "R2", "request count", 64'(rec_n), 64'(2 * D));
      for (int k = 0; k < 2 * D; k++) begin
         logic [AW-1:0] e;
         e = ((k % 2) ? 16'h0800 : 16'h0700) + AW'(k / 2 + 1);
         chk(rec_line[k] == e, "R8", "request line order", 64'(rec_line[k]), 64'(e));
      end
      chk(rec_id[0] == 4'h0, "R10", "first id", 64'(rec_id[0]), 64'h0);
      chk(rec_id[1] == 4'h4, "R10", "second id", 64'(rec_id[1]), 64'h4);
      chk(rec_id[3] == 4'h5, "R10", "fourth id", 64'(rec_id[3]), 64'h5);

      // flush with requests in flight, hit on unfilled slot (R7, R9)
      do_reset();
      lat = 40;
      do_lookup(16'h0A00, hit, dat, rl, w);
      do_lookup(16'h0B00, hit, dat, rl, w);
      do_lookup(16'h0C00, hit, dat, rl, w);
      do_lookup(16'h0D00, hit, dat, rl, w);
      do_lookup(16'h0E00, hit, dat, rl, w);
      chk(hit == 1'b0, "R2", "res_hit 0E00", 64'(hit), 64'd0);
      do_lookup(16'h0E01, hit, dat, rl, w);
      chk(hit == 1'b1, "R7", "res_hit 0E01", 64'(hit), 64'd1);
      chk(w >= 40, "R7", "wait cycles 0E01", 64'(w), 64'd40);
      chk(dat == fdata(16'h0E01), "R9", "data 0E01", 64'(dat), 64'(fdata(16'h0E01)));
      lat = 6;

      // vector table (R2..R6)
      do_reset();
      for (int i = 0; i < NV; i++) begin
         logic [AW-1:0] ln;
         logic eh;
         ln = VEC[i][AW-1:0];
         eh = VEC[i][AW];
         do_lookup(ln, hit, dat, rl, w);
         chk(hit == eh, vtag(i), "res_hit", 64'(hit), 64'(eh));
         chk(rl == ln, "R4", "res_line", 64'(rl), 64'(ln));
         if (eh) begin
            chk(dat == fdata(ln), vtag(i), "res_data", 64'(dat), 64'(fdata(ln)));
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule